// File: doc/BRIEF.md
# Four-Level Prioritised Interrupt Request Hub

The hub collects four active-low interrupt request lines, one per priority level 4, 5, 6 and 7, with level 7 the most urgent. Each line first passes through a two-flop synchroniser. A top-down mask then keeps only the highest asserted level. That level is admitted only when the processor's global interrupt enable is set and the level is strictly above the processor's 3-bit execution priority. An admitted level raises a single registered interrupt request towards the processor.

When the processor raises its acknowledge input, the hub latches the level admitted in that cycle. It then drives the matching active-high per-level acknowledge line and reports the level number. The latched grant stays fixed for as long as the processor holds its acknowledge high, and it is released when the acknowledge falls. A lower request that was masked stays pending for as long as its device holds it. It is granted on a later acknowledge once the higher request has gone.

Top module: `irq_prio_hub`

## Requirements
- R1: While reset is asserted, and right after it, `irq_out`, `lvl_ack` and `grant_lvl` are all zero.
- R2: With `glb_en` low, `irq_out` stays low whatever the requests are.
- R3: Request bit i of `req_n` (driven low) stands for level 4+i. Of the levels asserted together, only the highest one is considered; all lower ones are masked.
- R4: The considered level is admitted only if it is strictly greater than `cpu_prio`, read as unsigned. An equal level is refused, and a refused top level does not let a lower level through.
- R5: `irq_out` is high exactly when an admitted level exists, and low when no request is asserted.
- R6: One cycle after `cpu_ack` is first seen high with a level admitted, exactly one bit of `lvl_ack` goes high: bit i for level 4+i. At the same time `grant_lvl` shows that level number. `lvl_ack` never has more than one bit set.
- R7: While `cpu_ack` stays high, the grant (`lvl_ack`, `grant_lvl`) does not change, even if the requests change. In the cycle after `cpu_ack` is low, both are zero.
- R8: A masked lower request that is still asserted is granted by a later acknowledge, once the higher request has been removed.
- R9: A request change first shows on `irq_out` after the third rising clock edge, counted from the first edge that samples it.
- R10: An acknowledge that rises while no level is admitted asserts no `lvl_ack` bit. A level admitted later during that same acknowledge is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low requests; bit i is level 4+i |
| glb_en | input | 1 | Processor global interrupt enable |
| cpu_prio | input | 3 | Processor execution priority (unsigned) |
| cpu_ack | input | 1 | Processor acknowledge, held high for the whole acknowledge cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| lvl_ack | output | 4 | Active-high acknowledge; bit i is level 4+i |
| grant_lvl | output | 3 | Granted level number, 0 when no grant is held |

## Verification
The assertions assume that `cpu_ack` is a clean level from the processor's own clock domain, with one rising edge per acknowledge cycle. They also assume that `glb_en` and `cpu_prio` change synchronously to `clk`. Only `req_n` is taken to be asynchronous. The stimulus drives every input on the falling clock edge and keeps each request vector steady long enough to cross the synchroniser before an acknowledge is raised. The only exceptions are the directed cases that change requests on purpose during a held acknowledge, or while an acknowledge is raised with nothing admitted.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int HUB_LVLS   = 4;  // number of request levels
    localparam int HUB_BASE   = 4;  // level number of request bit 0
    localparam int HUB_PRIO_W = 3;  // width of priority / level numbers
    localparam int HUB_SYNC   = 2;  // synchroniser depth

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irq_rank.sv
module irq_rank #(
    parameter int NUM  = 4,
    parameter int BASE = 4,
    parameter int PW   = 3,
    localparam int IW  = irq_hub_pkg::idx_width(NUM)
) (
    input  logic [NUM-1:0] pend,
    input  logic           en,
    input  logic [PW-1:0]  prio,
    output logic [IW-1:0]  sel_idx,
    output logic           admit
);
    localparam logic [PW-1:0] BASE_V = PW'(BASE);

    logic [NUM-1:0] win;
    logic           sel_vld;
    logic [PW-1:0]  sel_lvl;

    // top-down mask: a level survives only if nothing above it is asserted
    for (genvar g = 0; g < NUM; g++) begin : g_mask
        if (g == NUM - 1) begin : g_top
            assign win[g] = pend[g];
        end else begin : g_low
            assign win[g] = pend[g] & ~(|pend[NUM-1:g+1]);
        end
    end

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NUM; i++) begin
            if (win[i]) sel_idx = IW'(i);
        end
    end

    assign sel_vld = |win;
    assign sel_lvl = BASE_V + PW'(sel_idx);
    assign admit   = en & sel_vld & (sel_lvl > prio);
endmodule

// File: rtl/irq_grant.sv
module irq_grant #(
    parameter int NUM  = 4,
    parameter int BASE = 4,
    parameter int PW   = 3,
    localparam int IW  = irq_hub_pkg::idx_width(NUM)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           admit,
    input  logic [IW-1:0]  sel_idx,
    input  logic           cpu_ack,
    output logic           irq_out,
    output logic [NUM-1:0] lvl_ack,
    output logic [PW-1:0]  grant_lvl
);
    typedef struct packed {
        logic          irq;
        logic          held;
        logic          ack_seen;
        logic [IW-1:0] idx;
    } grant_st_t;

    grant_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.irq      = admit;
        st_d.ack_seen = cpu_ack;
        if (!cpu_ack) begin
            st_d.held = 1'b0;
        end else if (!st_q.ack_seen && admit) begin
            st_d.held = 1'b1;
            st_d.idx  = sel_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM; g++) begin : g_ack
        assign lvl_ack[g] = st_q.held && (st_q.idx == IW'(g));
    end

    assign irq_out   = st_q.irq;
    assign grant_lvl = st_q.held ? (PW'(BASE) + PW'(st_q.idx)) : '0;
endmodule

// File: rtl/irq_prio_hub.sv
module irq_prio_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM    = HUB_LVLS,
    parameter int BASE   = HUB_BASE,
    parameter int PW     = HUB_PRIO_W,
    parameter int STAGES = HUB_SYNC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] req_n,
    input  logic           glb_en,
    input  logic [PW-1:0]  cpu_prio,
    input  logic           cpu_ack,
    output logic           irq_out,
    output logic [NUM-1:0] lvl_ack,
    output logic [PW-1:0]  grant_lvl
);
    localparam int IW = idx_width(NUM);

    logic [NUM-1:0] pend;
    logic [IW-1:0]  sel_idx;
    logic           admit;

    irq_sync #(.W(NUM), .STAGES(STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (~req_n),
        .dout (pend)
    );

    irq_rank #(.NUM(NUM), .BASE(BASE), .PW(PW)) i_rank (
        .pend   (pend),
        .en     (glb_en),
        .prio   (cpu_prio),
        .sel_idx(sel_idx),
        .admit  (admit)
    );

    irq_grant #(.NUM(NUM), .BASE(BASE), .PW(PW)) i_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .admit    (admit),
        .sel_idx  (sel_idx),
        .cpu_ack  (cpu_ack),
        .irq_out  (irq_out),
        .lvl_ack  (lvl_ack),
        .grant_lvl(grant_lvl)
    );
endmodule

// File: rtl/irq_prio_hub_chk.sv
module irq_prio_hub_chk #(
    parameter int NUM = 4,
    parameter int PW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           glb_en,
    input logic [PW-1:0]  cpu_prio,
    input logic           cpu_ack,
    input logic           irq_out,
    input logic [NUM-1:0] lvl_ack,
    input logic [PW-1:0]  grant_lvl
);
    p_onehot_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lvl_ack));

    p_ack_after_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl_ack) |-> $past(cpu_ack));

    p_lvl_has_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_lvl != '0) |-> (|lvl_ack));

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(glb_en) |-> !irq_out);

    p_top_prio_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(cpu_prio)) |-> !irq_out);

    p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lvl_ack) && cpu_ack) |=> ($stable(lvl_ack) && $stable(grant_lvl)));

    p_grant_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |=> ((lvl_ack == '0) && (grant_lvl == '0)));
endmodule

bind irq_prio_hub irq_prio_hub_chk #(.NUM(NUM), .PW(PW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .cpu_prio (cpu_prio),
    .cpu_ack  (cpu_ack),
    .irq_out  (irq_out),
    .lvl_ack  (lvl_ack),
    .grant_lvl(grant_lvl)
);

// File: tb/test_irq_prio_hub.sv
module test_irq_prio_hub;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       glb_en = 1'b0;
    logic [2:0] cpu_prio = 3'd0;
    logic       cpu_ack = 1'b0;
    logic       irq_out;
    logic [3:0] lvl_ack;
    logic [2:0] grant_lvl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_hub i_irq_prio_hub (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .glb_en(glb_en),
        .cpu_prio(cpu_prio), .cpu_ack(cpu_ack), .irq_out(irq_out),
        .lvl_ack(lvl_ack), .grant_lvl(grant_lvl)
    );

    // {req_n[3:0], glb_en, cpu_prio[2:0], exp_irq, exp_lvl[2:0]}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        12'b1111_1_000_0_000,   // idle                       R5
        12'b1110_1_000_1_100,   // level 4 alone              R3
        12'b0000_1_000_1_111,   // all levels, 7 wins         R3
        12'b0101_1_000_1_111,   // 7 and 5                    R3
        12'b1010_1_000_1_110,   // 6 and 4                    R3
        12'b1011_1_110_0_000,   // 6 at prio 6, refused       R4
        12'b1011_1_101_1_110,   // 6 at prio 5                R4
        12'b0000_0_000_0_000,   // all, disabled              R2
        12'b0111_1_111_0_000,   // 7 at prio 7                R4
        12'b1101_1_100_1_101,   // 5 at prio 4                R4
        12'b1001_1_110_0_000,   // 6 refused masks 5          R4
        12'b0111_1_110_1_111    // 7 at prio 6                R4
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack_pulse_check(input string tag, input int exp_ack, input int exp_lvl);
        cpu_ack = 1'b1;
        cyc(1);
        chk({tag, " lvl_ack"}, int'(lvl_ack), exp_ack);
        chk({tag, " grant_lvl"}, int'(grant_lvl), exp_lvl);
        cpu_ack = 1'b0;
        cyc(1);
        chk({tag, " release R7"}, int'(lvl_ack), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", int'(irq_out), 0);
        chk("R1 ack in reset", int'(lvl_ack), 0);
        chk("R1 lvl in reset", int'(grant_lvl), 0);
        rst_n = 1'b1;
        glb_en = 1'b1;
        cyc(1);
        chk("R1 irq after reset", int'(irq_out), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [11:0] e;
            int exp_ack;
            e = VEC[v];
            req_n    = e[11:8];
            glb_en   = e[7];
            cpu_prio = e[6:4];
            cyc(4);
            chk($sformatf("R5 vec%0d irq", v), int'(irq_out), int'(e[3]));
            exp_ack = e[3] ? (1 << (int'(e[2:0]) - 4)) : 0;
            ack_pulse_check($sformatf("R6 vec%0d", v), exp_ack, e[3] ? int'(e[2:0]) : 0);
        end

        // R9: synchroniser latency
        req_n = 4'hF; glb_en = 1'b1; cpu_prio = 3'd0;
        cyc(4);
        req_n = 4'b1101;
        cyc(2);
        chk("R9 irq after two edges", int'(irq_out), 0);
        cyc(1);
        chk("R9 irq after three edges", int'(irq_out), 1);

        // R7: grant held while ack high, requests change
        cpu_ack = 1'b1;
        cyc(1);
        chk("R7 first grant", int'(lvl_ack), 4'b0010);
        req_n = 4'b0101;
        cyc(5);
        chk("R7 held line", int'(lvl_ack), 4'b0010);
        chk("R7 held level", int'(grant_lvl), 5);
        cpu_ack = 1'b0;
        cyc(1);
        chk("R7 released", int'(lvl_ack), 0);
        ack_pulse_check("R7 regrant to 7", 4'b1000, 7);

        // R8: masked lower request served after higher drops
        req_n = 4'b0110;
        cyc(4);
        ack_pulse_check("R8 high first", 4'b1000, 7);
        req_n = 4'b1110;
        cyc(4);
        chk("R8 irq for pending 4", int'(irq_out), 1);
        ack_pulse_check("R8 lower served", 4'b0001, 4);

        // R10: ack with nothing admitted, then request during the ack
        req_n = 4'hF;
        cyc(4);
        cpu_ack = 1'b1;
        cyc(1);
        chk("R10 empty ack", int'(lvl_ack), 0);
        req_n = 4'b1011;
        cyc(5);
        chk("R10 late request irq", int'(irq_out), 1);
        chk("R10 late request not granted", int'(lvl_ack), 0);
        cpu_ack = 1'b0;
        cyc(1);
        ack_pulse_check("R10 next ack grants", 4'b0100, 6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule